// File: doc/BRIEF.md
# Linked-List DMA Command Sequencer

This block is the control side of one DMA channel. It runs a chain of command records kept in memory. Software first loads the address of the first record into a next-command pointer. It then adds to a counting semaphore. Each semaphore count lets the channel run one command.

For each command, the channel copies the next-command pointer into a current-command pointer. It reads the four-word record over a request/response fetch port and decodes the control word. It then runs the command and picks the address of the following record.

A command can do one of three things. It can complete without moving data. It can hand a transfer to the peripheral over a single request/acknowledge pair. It can branch on the level of an external sense bit. Combining these lets a list poll a peripheral status flag in a loop until the flag changes.

The semaphore takes software additions and hardware decrements on the same clock edge without losing either one. That lets software append work to a list that is still running.

Record layout, in 32-bit words at byte offsets 0, 4, 8 and 12:
- word 0: address of the following record.
- word 1: control word.
- word 2: alternate branch address.
- word 3: reserved.

Control word fields:
- bits [1:0]: type. 0 means no-transfer, 1 or 3 means transfer, 2 means sense.
- bit 2: chain.
- bit 3: decrement semaphore.
- bit 4: wait for acknowledge.
- bits [31:16]: transfer byte count.

Top module: `dma_chain_seq`

## Requirements
- R1: Asynchronous reset and the synchronous `chan_reset` input both return the channel to idle (`busy` low) and clear the semaphore, the current-command pointer and the next-command pointer.
- R2: A write on `sw_sem_we` adds `sw_sem_inc` to the semaphore. It never overwrites it, and the count saturates at 255.
- R3: When a software add and a hardware decrement fall on the same clock edge, the count becomes old + written − 1.
- R4: When the channel is idle, not frozen, not halted and the semaphore is nonzero, it loads the current pointer from the next pointer. It then reads the four words at current, current+4, current+8 and current+12, one request at a time, waiting for each response before issuing the next.
- R5: `cur_ptr` holds the address of the record being processed for the whole time that record is fetched and run.
- R6: A no-transfer command (type 0) completes without raising `per_req`.
- R7: A transfer command (type 1 or 3) raises `per_req` with `xfer_bytes` equal to control bits [31:16]. With bit 4 set it completes in the cycle `per_ack` is high. With bit 4 clear it completes after exactly one `per_req` cycle.
- R8: A sense command (type 2) takes its following address from word 2 when `sense_in` is high at completion, and from word 0 when it is low. All other types always take word 0.
- R9: A command with bit 3 set decrements the semaphore when it completes. The channel goes straight on to the following record only when bit 2 is set and the updated count is nonzero. Otherwise it returns to idle and resumes from the following record once the count becomes nonzero.
- R10: A command that completes with bit 2 clear leaves the channel halted in idle, even with a nonzero semaphore, until the next semaphore write. A write of zero also releases it.
- R11: While `freeze` is high, no fetch request, peripheral request or command completion occurs and the current pointer does not move. Software semaphore adds still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_reset | input | 1 | Synchronous channel reset to idle |
| freeze | input | 1 | Holds the channel in its current state |
| sw_nxt_we | input | 1 | Software write strobe for the next-command pointer |
| sw_nxt_addr | input | AW | Value written to the next-command pointer |
| sw_sem_we | input | 1 | Software add strobe for the semaphore |
| sw_sem_inc | input | SEM_W | Amount added to the semaphore |
| rd_valid | output | 1 | Fetch read request |
| rd_ready | input | 1 | Fetch request accepted |
| rd_addr | output | AW | Byte address of the word requested |
| rsp_valid | input | 1 | Fetch response present |
| rsp_data | input | 32 | Fetched word |
| per_req | output | 1 | Transfer request to the peripheral |
| per_ack | input | 1 | Peripheral acknowledge |
| xfer_bytes | output | 16 | Byte count of the current transfer |
| sense_in | input | 1 | External status bit tested by sense commands |
| cur_ptr | output | AW | Address of the record being processed |
| sem_count | output | SEM_W | Semaphore count |
| busy | output | 1 | Channel is not idle |
| cmd_done | output | 1 | Pulses in the cycle a command completes |

## Verification
The sequencer is exercised with a single no-transfer record, which isolates the start and completion path from any chaining. A linear three-record chain run with too few semaphore counts shows whether the count, rather than the chain flag, stops the walk, and whether a later add resumes it at the right record.

A two-record polling loop is run first with the sense bit low and then high. This separates the two branch targets and checks that a sense command picks the alternate word only when the bit is set.

Transfer records with and without the acknowledge wait tell a held request apart from a one-cycle request. One acknowledge is made to coincide with a software add, which checks that both semaphore updates land on the same edge. Freezing with the channel idle and again mid-transfer checks that the channel holds its state and drops its requests, while semaphore adds still take effect.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW    = 32,
  parameter int SEM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_reset,
  input  logic             freeze,
  input  logic             sw_nxt_we,
  input  logic [AW-1:0]    sw_nxt_addr,
  input  logic             sw_sem_we,
  input  logic [SEM_W-1:0] sw_sem_inc,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_data,
  output logic             per_req,
  input  logic             per_ack,
  output logic [15:0]      xfer_bytes,
  input  logic             sense_in,
  output logic [AW-1:0]    cur_ptr,
  output logic [SEM_W-1:0] sem_count,
  output logic             busy,
  output logic             cmd_done
);

  localparam logic [SEM_W:0] SEM_MAX = {1'b0, {SEM_W{1'b1}}};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_EXEC} state_t;
  state_t state;

  logic [AW-1:0]    nxt_q, cur_q, link_q, alt_q;
  logic [1:0]       typ_q, idx_q;
  logic             chain_q, dec_q, wend_q, halted_q;
  logic [15:0]      bytes_q;
  logic [SEM_W-1:0] sem_q;

  logic             is_xfer, is_sense, exec_done, dec_fire, start, cont;
  logic [AW-1:0]    branch;
  logic [SEM_W:0]   sum, dif;
  logic [SEM_W-1:0] sem_nx;
  logic             unused_bits;

  assign unused_bits = ^{rsp_data[15:5]};

  assign is_xfer   = typ_q[0];
  assign is_sense  = (typ_q == 2'd2);
  assign exec_done = (state == S_EXEC) && !freeze && (!is_xfer || !wend_q || per_ack);
  assign dec_fire  = exec_done && dec_q;
  assign branch    = (is_sense && sense_in) ? alt_q : link_q;
  assign start     = (state == S_IDLE) && !freeze && !halted_q && (sem_q != '0);

  assign sum    = {1'b0, sem_q} + (sw_sem_we ? {1'b0, sw_sem_inc} : '0);
  assign dif    = sum - {{SEM_W{1'b0}}, (dec_fire && sum != '0)};
  assign sem_nx = (dif > SEM_MAX) ? SEM_MAX[SEM_W-1:0] : dif[SEM_W-1:0];
  assign cont   = chain_q && (sem_nx != '0);

  assign rd_valid   = (state == S_FETCH) && !freeze;
  assign rd_addr    = cur_q + {{(AW-4){1'b0}}, idx_q, 2'b00};
  assign per_req    = (state == S_EXEC) && is_xfer && !freeze;
  assign xfer_bytes = bytes_q;
  assign cur_ptr    = cur_q;
  assign sem_count  = sem_q;
  assign busy       = (state != S_IDLE);
  assign cmd_done   = exec_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      nxt_q    <= '0;
      cur_q    <= '0;
      link_q   <= '0;
      alt_q    <= '0;
      typ_q    <= '0;
      idx_q    <= '0;
      chain_q  <= 1'b0;
      dec_q    <= 1'b0;
      wend_q   <= 1'b0;
      halted_q <= 1'b0;
      bytes_q  <= '0;
      sem_q    <= '0;
    end else if (chan_reset) begin
      state    <= S_IDLE;
      nxt_q    <= '0;
      cur_q    <= '0;
      idx_q    <= '0;
      halted_q <= 1'b0;
      sem_q    <= '0;
    end else begin
      sem_q <= sem_nx;

      if (exec_done)      nxt_q <= branch;
      else if (sw_nxt_we) nxt_q <= sw_nxt_addr;

      if (exec_done && !chain_q) halted_q <= 1'b1;
      if (sw_sem_we)             halted_q <= 1'b0;

      unique case (state)
        S_IDLE: if (start) begin
          cur_q <= nxt_q;
          idx_q <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (!freeze && rd_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          unique case (idx_q)
            2'd0: link_q <= rsp_data[AW-1:0];
            2'd1: begin
              typ_q   <= rsp_data[1:0];
              chain_q <= rsp_data[2];
              dec_q   <= rsp_data[3];
              wend_q  <= rsp_data[4];
              bytes_q <= rsp_data[31:16];
            end
            2'd2: alt_q <= rsp_data[AW-1:0];
            default: ;
          endcase
          if (idx_q == 2'd3) state <= S_EXEC;
          else begin
            idx_q <= idx_q + 2'd1;
            state <= S_FETCH;
          end
        end
        S_EXEC: if (exec_done) begin
          if (cont) begin
            cur_q <= branch;
            idx_q <= '0;
            state <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int AW    = 32,
  parameter int SEM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_reset,
  input logic             freeze,
  input logic             sw_sem_we,
  input logic [SEM_W-1:0] sw_sem_inc,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [AW-1:0]    rd_addr,
  input logic             per_req,
  input logic             cmd_done,
  input logic             busy,
  input logic [SEM_W-1:0] sem_count,
  input logic [AW-1:0]    cur_ptr,
  input logic             dec_fire
);

  localparam logic [SEM_W:0] SEM_MAX = {1'b0, {SEM_W{1'b1}}};
  localparam logic [SEM_W:0] ONE     = {{SEM_W{1'b0}}, 1'b1};

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> (sem_count == '0 && cur_ptr == '0 && !busy));

  p_sem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_sem_we && !dec_fire && !chan_reset) |=> $stable(sem_count));

  p_same_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_sem_we && dec_fire && !chan_reset &&
     ({1'b0, sem_count} + {1'b0, sw_sem_inc} <= SEM_MAX))
    |=> ({1'b0, sem_count} == {1'b0, $past(sem_count)} + {1'b0, $past(sw_sem_inc)} - ONE));

  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !chan_reset) |=> (freeze || (rd_valid && $stable(rd_addr))));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !per_req && !cmd_done));

  p_cur_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_done && !chan_reset) |=> $stable(cur_ptr));

  p_freeze_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!rd_valid && !per_req && !cmd_done));

endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(AW), .SEM_W(SEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .freeze(freeze),
  .sw_sem_we(sw_sem_we), .sw_sem_inc(sw_sem_inc), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .per_req(per_req),
  .cmd_done(cmd_done), .busy(busy), .sem_count(sem_count),
  .cur_ptr(cur_ptr), .dec_fire(dec_fire)
);

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;
  logic        clk = 0, rst_n = 0, chan_reset = 0, freeze = 0;
  logic        sw_nxt_we = 0, sw_sem_we = 0;
  logic [31:0] sw_nxt_addr = 0;
  logic [7:0]  sw_sem_inc = 0;
  logic        rd_valid, rd_ready = 1, rsp_valid = 0, per_req, per_ack = 0, sense_in = 0;
  logic [31:0] rd_addr, rsp_data = 0, cur_ptr;
  logic [15:0] xfer_bytes;
  logic [7:0]  sem_count;
  logic        busy, cmd_done;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:63];
  logic [31:0] done_log [0:15];
  logic [31:0] fetch_log [0:15];
  int ndone = 0, nfetch = 0, nreq = 0;
  logic [15:0] seen_bytes = 0;
  logic        pend = 0;
  logic [5:0]  paddr = 0;

  always #10 clk = ~clk;

  dma_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .freeze(freeze),
    .sw_nxt_we(sw_nxt_we), .sw_nxt_addr(sw_nxt_addr), .sw_sem_we(sw_sem_we),
    .sw_sem_inc(sw_sem_inc), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .per_req(per_req), .per_ack(per_ack), .xfer_bytes(xfer_bytes),
    .sense_in(sense_in), .cur_ptr(cur_ptr), .sem_count(sem_count),
    .busy(busy), .cmd_done(cmd_done)
  );

  always @(negedge clk) begin
    rsp_valid <= pend;
    rsp_data  <= mem[paddr];
    pend      <= rd_valid;
    paddr     <= rd_addr[7:2];
    if (rst_n) begin
      if (cmd_done) begin
        if (ndone < 16) done_log[ndone] = cur_ptr;
        ndone++;
      end
      if (rd_valid) begin
        if (nfetch < 16) fetch_log[nfetch] = rd_addr;
        nfetch++;
      end
      if (per_req) begin
        nreq++;
        seen_bytes = xfer_bytes;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input int typ, input bit chain, input bit dec,
                                      input bit wend, input logic [15:0] bytes);
    return {bytes, 11'd0, wend, dec, chain, typ[1:0]};
  endfunction

  task automatic put_cmd(input logic [7:0] a, input logic [31:0] nx,
                         input logic [31:0] c, input logic [31:0] alt);
    mem[a[7:2]]     = nx;
    mem[a[7:2] + 1] = c;
    mem[a[7:2] + 2] = alt;
    mem[a[7:2] + 3] = 32'h0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_logs;
    @(negedge clk);
    ndone = 0; nfetch = 0; nreq = 0; seen_bytes = 0;
  endtask

  task automatic reset_chan;
    @(posedge clk); #2 chan_reset = 1;
    @(posedge clk); #2 chan_reset = 0;
    clear_logs();
  endtask

  task automatic set_nxt(input logic [31:0] a);
    @(posedge clk); #2 sw_nxt_we = 1; sw_nxt_addr = a;
    @(posedge clk); #2 sw_nxt_we = 0;
  endtask

  task automatic sem_add(input logic [7:0] v);
    @(posedge clk); #2 sw_sem_we = 1; sw_sem_inc = v;
    @(posedge clk); #2 sw_sem_we = 0; sw_sem_inc = 0;
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    tick(3);
    while (busy && n < 2000) begin tick(1); n++; end
    if (busy) chk(req, 32'd1, 32'd0);
  endtask

  task automatic wait_req(input string req);
    int n;
    n = 0;
    while (!per_req && n < 500) begin tick(1); n++; end
    if (!per_req) chk(req, 32'd0, 32'd1);
  endtask

  task automatic t_reset;
    tick(1);
    chk("R1 sem after reset", {24'd0, sem_count}, 0);
    chk("R1 cur after reset", cur_ptr, 0);
    chk("R1 busy after reset", {31'd0, busy}, 0);
    put_cmd(8'h00, 32'h0, ctl(0, 0, 1, 0, 0), 32'h0);
    sem_add(1);
    wait_idle("R1 idle");
    chk("R1 next pointer starts at zero", fetch_log[0], 32'h0);
  endtask

  task automatic t_single_nox;
    reset_chan();
    put_cmd(8'h60, 32'h0, ctl(0, 0, 1, 0, 16'h0020), 32'h0);
    set_nxt(32'h60);
    sem_add(1);
    wait_idle("R6 idle");
    chk("R6 no per_req", nreq, 0);
    chk("R6 one completion", ndone, 1);
    chk("R5 cur at done", done_log[0], 32'h60);
    chk("R9 sem decremented", {24'd0, sem_count}, 0);
  endtask

  task automatic t_chain_sem;
    reset_chan();
    put_cmd(8'h40, 32'h50, ctl(0, 1, 1, 0, 0), 32'h0);
    put_cmd(8'h50, 32'h80, ctl(0, 1, 1, 0, 0), 32'h0);
    put_cmd(8'h80, 32'h40, ctl(0, 1, 1, 0, 0), 32'h0);
    set_nxt(32'h40);
    sem_add(2);
    wait_idle("R9 idle");
    chk("R4 word0 addr", fetch_log[0], 32'h40);
    chk("R4 word1 addr", fetch_log[1], 32'h44);
    chk("R4 word2 addr", fetch_log[2], 32'h48);
    chk("R4 word3 addr", fetch_log[3], 32'h4C);
    chk("R9 stops on zero count", ndone, 2);
    chk("R5 second record", done_log[1], 32'h50);
    chk("R9 count zero", {24'd0, sem_count}, 0);
    sem_add(1);
    wait_idle("R9 resume");
    chk("R9 resumes at third", done_log[2], 32'h80);
    chk("R9 one more run", ndone, 3);
  endtask

  task automatic t_sense_loop;
    reset_chan();
    sense_in = 0;
    put_cmd(8'h00, 32'h10, ctl(0, 1, 0, 0, 0), 32'h0);
    put_cmd(8'h10, 32'h00, ctl(2, 1, 0, 0, 0), 32'h20);
    put_cmd(8'h20, 32'h00, ctl(0, 0, 0, 0, 0), 32'h0);
    set_nxt(32'h0);
    sem_add(1);
    begin
      int n;
      n = 0;
      while (ndone < 5 && n < 1000) begin tick(1); n++; end
    end
    chk("R8 loop a", done_log[0], 32'h00);
    chk("R8 loop b", done_log[1], 32'h10);
    chk("R8 sense low takes word0", done_log[2], 32'h00);
    chk("R8 loop d", done_log[3], 32'h10);
    @(posedge clk); #2 sense_in = 1;
    wait_idle("R8 exit");
    chk("R8 sense high takes word2", done_log[ndone-1], 32'h20);
    chk("R8 exit from sense", done_log[ndone-2], 32'h10);
    chk("R9 no decrement", {24'd0, sem_count}, 1);
    sense_in = 0;
  endtask

  task automatic t_xfer_nowait;
    reset_chan();
    put_cmd(8'h30, 32'h0, ctl(1, 0, 1, 0, 16'h0040), 32'h0);
    set_nxt(32'h30);
    sem_add(1);
    wait_idle("R7 idle");
    chk("R7 one request cycle", nreq, 1);
    chk("R7 byte count", {16'd0, seen_bytes}, 32'h40);
    chk("R7 completes", ndone, 1);
  endtask

  task automatic t_same_edge;
    reset_chan();
    put_cmd(8'h90, 32'hA0, ctl(3, 1, 1, 1, 16'h0100), 32'h0);
    put_cmd(8'hA0, 32'h0, ctl(0, 0, 0, 0, 0), 32'h0);
    set_nxt(32'h90);
    sem_add(3);
    wait_req("R7 request");
    tick(3);
    chk("R7 held until ack", ndone, 0);
    chk("R3 before", {24'd0, sem_count}, 3);
    @(posedge clk); #2 per_ack = 1; sw_sem_we = 1; sw_sem_inc = 5;
    @(posedge clk); #2 per_ack = 0; sw_sem_we = 0; sw_sem_inc = 0;
    tick(1);
    chk("R3 add and decrement", {24'd0, sem_count}, 7);
    wait_idle("R3 idle");
    chk("R3 count kept", {24'd0, sem_count}, 7);
    chk("R7 bytes", {16'd0, seen_bytes}, 32'h100);
    reset_chan();
    chk("R1 chan_reset sem", {24'd0, sem_count}, 0);
    chk("R1 chan_reset cur", cur_ptr, 0);
  endtask

  task automatic t_halt_kick;
    reset_chan();
    put_cmd(8'hC0, 32'hC0, ctl(0, 0, 0, 0, 0), 32'h0);
    set_nxt(32'hC0);
    sem_add(1);
    wait_idle("R10 idle");
    tick(10);
    chk("R10 halted once", ndone, 1);
    chk("R10 count kept", {24'd0, sem_count}, 1);
    chk("R10 not busy", {31'd0, busy}, 0);
    sem_add(0);
    wait_idle("R10 rerun");
    chk("R10 zero write releases", ndone, 2);
  endtask

  task automatic t_freeze_sat;
    reset_chan();
    put_cmd(8'h00, 32'h0, ctl(0, 0, 0, 0, 0), 32'h0);
    @(posedge clk); #2 freeze = 1;
    sem_add(250);
    sem_add(10);
    tick(5);
    chk("R2 saturates", {24'd0, sem_count}, 255);
    chk("R11 no fetch frozen", nfetch, 0);
    chk("R11 idle frozen", {31'd0, busy}, 0);
    reset_chan();
    freeze = 0;
    put_cmd(8'hE0, 32'h0, ctl(1, 0, 1, 1, 16'h8), 32'h0);
    set_nxt(32'hE0);
    sem_add(1);
    wait_req("R11 request");
    @(posedge clk); #2 freeze = 1; per_ack = 1;
    tick(5);
    chk("R11 request dropped", {31'd0, per_req}, 0);
    chk("R11 no completion", ndone, 0);
    chk("R11 cur held", cur_ptr, 32'hE0);
    chk("R11 still busy", {31'd0, busy}, 1);
    @(posedge clk); #2 freeze = 0;
    @(posedge clk); #2 per_ack = 0;
    wait_idle("R11 idle");
    chk("R11 completes after release", ndone, 1);
    chk("R9 decremented", {24'd0, sem_count}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    tick(3);
    rst_n = 1;
    t_reset();
    t_single_nox();
    t_chain_sem();
    t_sense_loop();
    t_xfer_nowait();
    t_same_edge();
    t_halt_kick();
    t_freeze_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule